// File: doc/BRIEF.md
# Immediate Add Execution Unit with Carry Control

This block runs the add-immediate group of a 32-bit processor in one clock cycle. It takes an issued instruction word, the value of the source register and the current carry flag. It returns the destination index, the sum, a one-cycle result strobe, the new carry value and a carry-write enable. Two opcode bits act on their own. One chooses whether the incoming carry joins the sum. The other chooses whether the carry flag is updated or kept.

By default the operand is the 16-bit immediate field, sign-extended. A prefix instruction can load a 16-bit upper half into a one-shot latch. The next instruction that issues then uses a full 32-bit immediate built from the latched half and its own field, with no sign extension. That instruction clears the latch, even if it is not an add. The register file, fetch, pipeline control and the rest of the status register live elsewhere.

Top module: `iadd_unit`

## Requirements
- R1: An issued word (instr_valid_i=1) whose top three bits instr_i[31:29] are 001 and whose bit instr_i[26] is 0 is an add-immediate. The cycle after it issues, result_valid_o is 1 for that one cycle, and rd_idx_o equals instr_i[25:21].
- R2: With no prefix pending, the operand is instr_i[15:0] sign-extended to 32 bits, and result_o is ra_data_i plus that operand, modulo 2^32.
- R3: When the carry-use bit instr_i[27] is 1, carry_i is added into the sum. When it is 0, carry_i has no effect on result_o.
- R4: When the keep bit instr_i[28] is 0, carry_we_o is 1 with the result, and carry_o is bit 32 of the 33-bit sum ra + operand + carry-in.
- R5: When instr_i[28] is 1, carry_we_o is 0 with the result, and carry_o equals the carry_i value presented with the instruction.
- R6: With instr_i[28] and instr_i[27] both 1, carry_i is added into the sum and the carry flag is not written.
- R7: After a cycle with pfx_valid_i=1, the next issued add uses the operand {pfx_value_i, instr_i[15:0]} with no sign extension. The latch holds through cycles with no issue.
- R8: The next issued word clears a pending prefix, whether or not that word is an add-immediate. The add after it uses sign extension again.
- R9: An issued word whose opcode does not match 001xx0 gives result_valid_o=0 and carry_we_o=0 in the following cycle, and carry_o keeps its value.
- R10: While rst_ni is low, result_valid_o, carry_we_o and carry_o are 0 and the prefix latch is empty.
- R11: A cycle with instr_valid_i=0 gives result_valid_o=0 and carry_we_o=0 next cycle, and carry_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction issues this cycle |
| instr_i | input | 32 | Instruction word, MSB-first field layout |
| ra_data_i | input | 32 | Source register value |
| carry_i | input | 1 | Current carry flag |
| pfx_valid_i | input | 1 | Prefix instruction supplies an upper half this cycle |
| pfx_value_i | input | 16 | Upper half of the next immediate |
| rd_idx_o | output | 5 | Destination register index |
| result_o | output | 32 | Sum |
| result_valid_o | output | 1 | Result strobe, one cycle after issue |
| carry_o | output | 1 | New carry flag value |
| carry_we_o | output | 1 | Carry flag write enable |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath, a 16-bit immediate and 5-bit register indices. With these widths the prefix fills the operand exactly, so the concatenated form covers every bit of the sum. Operands such as 0xFFFFFFFF plus one, with and without carry-in, drive bit 32 of the sum. The bench runs all four combinations of the keep bit and the carry-use bit. It also sends a prefix followed by a non-add word, which shows that the prefix is cleared.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
  localparam int unsigned XLEN_DEF  = 32;
  localparam int unsigned IMM_W_DEF = 16;
  localparam int unsigned IDX_W_DEF = 5;
  localparam int unsigned OPC_W     = 6;

  // opcode pattern 0 0 1 K C 0, MSB first
  function automatic logic opc_is_add(input logic [OPC_W-1:0] opc);
    return (opc[5:3] == 3'b001) && !opc[0];
  endfunction
endpackage

// File: rtl/iadd_decode.sv
module iadd_decode
  import iadd_pkg::*;
#(
  parameter int unsigned XLEN  = XLEN_DEF,
  parameter int unsigned IMM_W = IMM_W_DEF,
  parameter int unsigned IDX_W = IDX_W_DEF
) (
  input  logic [XLEN-1:0]  instr_i,
  output logic             is_add_o,
  output logic             keep_o,
  output logic             use_c_o,
  output logic [IDX_W-1:0] rd_o,
  output logic [IMM_W-1:0] imm_o
);
  localparam int unsigned OPC_LSB = XLEN - OPC_W;
  localparam int unsigned RD_LSB  = OPC_LSB - IDX_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc      = instr_i[OPC_LSB +: OPC_W];
    is_add_o = opc_is_add(opc);
    keep_o   = opc[2];
    use_c_o  = opc[1];
    rd_o     = instr_i[RD_LSB +: IDX_W];
    imm_o    = instr_i[IMM_W-1:0];
  end
endmodule

// File: rtl/iadd_prefix.sv
module iadd_prefix #(
  parameter int unsigned IMM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pfx_valid_i,
  input  logic [IMM_W-1:0] pfx_value_i,
  input  logic             issue_i,
  output logic             hit_o,
  output logic [IMM_W-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      hi_o  <= '0;
    end else if (pfx_valid_i) begin
      hit_o <= 1'b1;
      hi_o  <= pfx_value_i;
    end else if (issue_i) begin
      hit_o <= 1'b0; // one-shot: any issued word consumes it
    end
  end
endmodule

// File: rtl/iadd_adder.sv
module iadd_adder #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             hit_i,
  input  logic [IMM_W-1:0] hi_i,
  input  logic             cin_i,
  output logic [XLEN-1:0]  sum_o,
  output logic             cout_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;
  localparam int unsigned PAD_W = XLEN - 2 * IMM_W;

  logic [XLEN-1:0] sext_op, pfx_op, op;
  logic [XLEN:0]   wide;

  assign sext_op = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  generate
    if (PAD_W == 0) begin : g_exact
      assign pfx_op = {hi_i, imm_i};
    end else begin : g_pad
      assign pfx_op = {{PAD_W{1'b0}}, hi_i, imm_i};
    end
  endgenerate

  always_comb begin
    op     = hit_i ? pfx_op : sext_op;
    wide   = {1'b0, a_i} + {1'b0, op} + {{XLEN{1'b0}}, cin_i};
    sum_o  = wide[XLEN-1:0];
    cout_o = wide[XLEN];
  end
endmodule

// File: rtl/iadd_unit.sv
module iadd_unit
  import iadd_pkg::*;
#(
  parameter int unsigned XLEN  = XLEN_DEF,
  parameter int unsigned IMM_W = IMM_W_DEF,
  parameter int unsigned IDX_W = IDX_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  ra_data_i,
  input  logic             carry_i,
  input  logic             pfx_valid_i,
  input  logic [IMM_W-1:0] pfx_value_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [XLEN-1:0]  result_o,
  output logic             result_valid_o,
  output logic             carry_o,
  output logic             carry_we_o
);
  logic             is_add, keep, use_c, hit, cout, fire;
  logic [IDX_W-1:0] rd;
  logic [IMM_W-1:0] imm, hi;
  logic [XLEN-1:0]  sum;

  iadd_decode #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
    .instr_i (instr_i),
    .is_add_o(is_add),
    .keep_o  (keep),
    .use_c_o (use_c),
    .rd_o    (rd),
    .imm_o   (imm)
  );

  iadd_prefix #(.IMM_W(IMM_W)) u_pfx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pfx_valid_i(pfx_valid_i),
    .pfx_value_i(pfx_value_i),
    .issue_i    (instr_valid_i),
    .hit_o      (hit),
    .hi_o       (hi)
  );

  iadd_adder #(.XLEN(XLEN), .IMM_W(IMM_W)) u_add (
    .a_i   (ra_data_i),
    .imm_i (imm),
    .hit_i (hit),
    .hi_i  (hi),
    .cin_i (use_c & carry_i),
    .sum_o (sum),
    .cout_o(cout)
  );

  assign fire = instr_valid_i & is_add;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      carry_we_o     <= 1'b0;
      carry_o        <= 1'b0;
      rd_idx_o       <= '0;
      result_o       <= '0;
    end else begin
      result_valid_o <= fire;
      carry_we_o     <= fire & ~keep;
      if (fire) begin
        rd_idx_o <= rd;
        result_o <= sum;
        carry_o  <= keep ? carry_i : cout;
      end
    end
  end
endmodule

// File: rtl/iadd_unit_chk.sv
module iadd_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_valid_i,
  input logic [XLEN-1:0] instr_i,
  input logic            carry_i,
  input logic            result_valid_o,
  input logic            carry_o,
  input logic            carry_we_o
);
  logic opc_ok;
  assign opc_ok = (instr_i[XLEN-1 -: 3] == 3'b001) && !instr_i[XLEN-6];

  AST_WE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_we_o |-> result_valid_o); // R4
  AST_VALID_NEEDS_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> !result_valid_o && !carry_we_o); // R11
  AST_BAD_OPCODE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !opc_ok |=> !result_valid_o && !carry_we_o && $stable(carry_o)); // R9
  AST_KEEP_BIT_GATES_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && opc_ok |=> carry_we_o == !$past(instr_i[XLEN-4])); // R4
  AST_KEEP_HOLDS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && opc_ok && instr_i[XLEN-4] |=> carry_o == $past(carry_i)); // R5
endmodule

bind iadd_unit iadd_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .carry_i       (carry_i),
  .result_valid_o(result_valid_o),
  .carry_o       (carry_o),
  .carry_we_o    (carry_we_o)
);

// File: tb/iadd_unit_test.sv
module iadd_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] ra_data_i = '0;
  logic        carry_i = 1'b0;
  logic        pfx_valid_i = 1'b0;
  logic [15:0] pfx_value_i = '0;
  logic [4:0]  rd_idx_o;
  logic [31:0] result_o;
  logic        result_valid_o, carry_o, carry_we_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  iadd_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .ra_data_i(ra_data_i), .carry_i(carry_i), .pfx_valid_i(pfx_valid_i),
    .pfx_value_i(pfx_value_i), .rd_idx_o(rd_idx_o), .result_o(result_o),
    .result_valid_o(result_valid_o), .carry_o(carry_o), .carry_we_o(carry_we_o)
  );

  typedef struct packed {
    logic        v;
    logic        we;
    logic        cf;
    logic [4:0]  rd;
    logic [31:0] res;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // bench model state
  logic        m_pv  = 1'b0;
  logic [15:0] m_phi = '0;
  logic        m_cf  = 1'b0;

  function automatic logic [31:0] mk(input bit k, input bit c, input logic [4:0] rd,
                                     input logic [15:0] imm);
    return {3'b001, k, c, 1'b0, rd, 5'd1, imm};
  endfunction

  task automatic issue(input bit iv, input logic [31:0] ins, input logic [31:0] ra,
                       input bit cin, input bit pv, input logic [15:0] ph, input string tag);
    exp_t        e;
    logic [31:0] op;
    logic [32:0] w;
    bit          add;
    instr_valid_i = iv; instr_i = ins; ra_data_i = ra; carry_i = cin;
    pfx_valid_i = pv; pfx_value_i = ph;
    add = iv && ins[31:29] == 3'b001 && !ins[26];
    op  = m_pv ? {m_phi, ins[15:0]} : {{16{ins[15]}}, ins[15:0]};
    w   = {1'b0, ra} + {1'b0, op} + {32'd0, ins[27] & cin};
    if (add) m_cf = ins[28] ? cin : w[32];
    e.v = add; e.we = add && !ins[28]; e.cf = m_cf; e.rd = ins[25:21]; e.res = w[31:0];
    if (pv) begin m_pv = 1'b1; m_phi = ph; end
    else if (iv) m_pv = 1'b0;
    @(posedge clk_i);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  task automatic idle(input string tag);
    issue(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 16'h0, tag);
  endtask

  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      bit    bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      bad = (result_valid_o !== e.v) || (carry_we_o !== e.we) || (carry_o !== e.cf);
      if (e.v) bad = bad || (rd_idx_o !== e.rd) || (result_o !== e.res);
      if (bad) begin
        n_fail++;
        $display("FAIL %s: got v=%0b we=%0b cf=%0b rd=%0d res=%h exp v=%0b we=%0b cf=%0b rd=%0d res=%h",
                 t, result_valid_o, carry_we_o, carry_o, rd_idx_o, result_o,
                 e.v, e.we, e.cf, e.rd, e.res);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    n_tests++;
    if (result_valid_o !== 1'b0 || carry_we_o !== 1'b0 || carry_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: got v=%0b we=%0b cf=%0b exp 0 0 0",
               result_valid_o, carry_we_o, carry_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    issue(1, mk(0, 0, 5'd3, 16'hFFFF), 32'd5, 0, 0, 0, "R2 R4 sext -1 carry out");
    issue(1, mk(0, 0, 5'd7, 16'h0001), 32'h7FFF_FFFF, 1, 0, 0, "R2 R3 no carry-in");
    issue(1, mk(0, 1, 5'd9, 16'd20), 32'd10, 1, 0, 0, "R3 carry-in added");
    issue(1, mk(0, 1, 5'd2, 16'h0000), 32'hFFFF_FFFF, 1, 0, 0, "R3 R4 carry via cin");
    issue(1, mk(1, 0, 5'd4, 16'h0001), 32'hFFFF_FFFF, 0, 0, 0, "R5 keep, cin 0");
    issue(1, mk(1, 0, 5'd4, 16'h0001), 32'hFFFF_FFFF, 1, 0, 0, "R5 keep, cin 1");
    issue(1, mk(1, 1, 5'd31, 16'h0000), 32'hFFFF_FFFF, 1, 0, 0, "R6 keep and carry-in");
    issue(1, mk(1, 1, 5'd30, 16'h8000), 32'h0000_0010, 0, 0, 0, "R6 keep and carry-in cin 0");
    idle("R11 idle");
    issue(1, 32'h0400_0000, 32'd1, 1, 0, 0, "R9 opcode 000001");
    issue(1, mk(0, 0, 5'd1, 16'h0) | 32'h0400_0000, 32'd1, 1, 0, 0, "R9 opcode 001001");
    issue(1, 32'hFFFF_FFFF, 32'd1, 1, 0, 0, "R9 opcode all ones");
    issue(0, mk(0, 0, 5'd6, 16'h0001), 32'hFFFF_FFFF, 0, 0, 0, "R11 add word not issued");
    issue(0, 32'h0, 32'h0, 0, 1, 16'h1234, "R7 prefix load");
    issue(1, mk(0, 0, 5'd8, 16'h8000), 32'h0000_0001, 0, 0, 0, "R7 prefix operand");
    issue(0, 32'h0, 32'h0, 0, 1, 16'hFFFF, "R7 prefix load 2");
    idle("R7 idle keeps latch");
    issue(1, mk(0, 1, 5'd12, 16'h0001), 32'h0000_FFFF, 1, 0, 0, "R7 prefix with carry-in");
    issue(0, 32'h0, 32'h0, 0, 1, 16'h00AA, "R8 prefix load");
    issue(1, 32'h0000_0000, 32'h0, 0, 0, 0, "R8 non-add consumes prefix");
    issue(1, mk(0, 0, 5'd13, 16'hFFFF), 32'd3, 0, 0, 0, "R8 back to sign extension");
    issue(1, mk(0, 0, 5'd14, 16'h7FFF), 32'd0, 0, 0, 0, "R1 rd index and positive imm");

    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      r = $urandom;
      issue(1, mk(r[0], r[1], r[6:2], r[31:16]), $urandom, r[7], r[8], r[15:0],
            "R1 R2 random add");
    end
    repeat (3) idle("R11 drain");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule